// File: doc/BRIEF.md
# Segmented Address Generator

This block keeps the four segment bases of a real-mode style processor (code, stack, data and extra), together with the instruction pointer and the stack pointer. It turns a segment base and a 16-bit offset into a 20-bit physical address. The base is scaled by sixteen and the offset is added to it. Any carry beyond the top of the 1 MB space is dropped, so addresses wrap back to zero.

Three addresses are produced at the same time:

- a general access address, for whichever segment the select code names plus an offset supplied on the ports;
- the instruction fetch address, code base plus instruction pointer;
- the stack address, stack base plus stack pointer.

Software-visible state changes only through three synchronous load ports and one advance command. The advance command moves the instruction pointer forward by the length of the instruction just executed. All address outputs are combinational views of the registered state and of the access inputs.

Top module: `seg_agu`

## Requirements
- R1: While reset is held and right after it, the code segment holds FFFF and the extra, stack and data segments, the instruction pointer and the stack pointer hold 0, so `fetch_addr` reads FFFF0 and `stk_addr` reads 00000.
- R2: `phys_addr` equals the segment picked by `acc_sel` times 16 plus `acc_disp`, with `acc_sel` encoded 00 = extra, 01 = code, 10 = stack, 11 = data.
- R3: A sum that reaches or passes 2^20 loses its carry, so the address wraps modulo 1 MB (FFFF:0010 gives 00000).
- R4: `fetch_addr` equals the code segment times 16 plus the instruction pointer.
- R5: An advance with `adv_en` high adds `adv_len` to the instruction pointer modulo 2^16 and leaves the code segment unchanged.
- R6: `stk_addr` equals the stack segment times 16 plus the stack pointer.
- R7: A register write shows on the outputs only after the next rising clock edge, and not in the cycle the write is presented.
- R8: When `ip_wr_en` and `adv_en` are high in the same cycle, the loaded value wins and the advance is dropped.
- R9: A segment write changes only the segment named by `seg_wr_sel` (same encoding as R2), and a stack pointer write loads `sp_wr_data`. Without a write, both stay unchanged.
- R10: With neither `ip_wr_en` nor `adv_en` high, the instruction pointer, and so `fetch_addr`, holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Load one segment register |
| seg_wr_sel | input | 2 | Segment to load (00 extra, 01 code, 10 stack, 11 data) |
| seg_wr_data | input | SEG_W | New segment value |
| ip_wr_en | input | 1 | Load the instruction pointer |
| ip_wr_data | input | DISP_W | New instruction pointer |
| adv_en | input | 1 | Advance the instruction pointer |
| adv_len | input | LEN_W | Length of the instruction just executed |
| sp_wr_en | input | 1 | Load the stack pointer |
| sp_wr_data | input | DISP_W | New stack pointer |
| acc_sel | input | 2 | Segment used for the general access |
| acc_disp | input | DISP_W | Offset for the general access |
| phys_addr | output | PA_W | General access physical address |
| fetch_addr | output | PA_W | Instruction fetch physical address |
| stk_addr | output | PA_W | Stack physical address |

## Verification
The bench builds the block with its default parameters:

- 16-bit segments and offsets;
- a shift of four;
- a 20-bit result;
- a 4-bit instruction length;
- a code segment that resets to FFFF.

With a 20-bit result the carry out of the top bit is reachable with ordinary values such as FFFF:0010 and FFFF:FFFF. With lengths up to 15 the pointer wrap at FFFE plus 5 is reachable in a single advance. The reset value of the code segment gives a non-zero fetch address straight out of reset, so a wrong reset constant or a wrong shift shows at once.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

   // Segment select encoding shared by the write port and the access port
   typedef enum logic [1:0] {
      SEG_ES = 2'b00,
      SEG_CS = 2'b01,
      SEG_SS = 2'b10,
      SEG_DS = 2'b11
   } seg_sel_e;

   localparam int SEG_COUNT = 4;
   localparam int SEL_BITS  = 2;

endpackage

// File: rtl/seg_agu_segbank.sv
module seg_agu_segbank
   import seg_agu_pkg::*;
#(
   parameter int              SEG_W  = 16,
   parameter logic [SEG_W-1:0] RST_CS = '1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [SEL_BITS-1:0]                  wr_sel,
   input  logic [SEG_W-1:0]                     wr_data,
   output logic [SEG_COUNT-1:0][SEG_W-1:0]      seg_q
);

   // One register per segment; the code segment has its own reset value
   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
      localparam logic [SEG_W-1:0] RV = (g == int'(SEG_CS)) ? RST_CS : '0;
      logic hit;

      assign hit = wr_en && (wr_sel == SEL_BITS'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seg_q[g] <= RV;
         end else if (hit) begin
            seg_q[g] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/seg_agu_ptr.sv
module seg_agu_ptr #(
   parameter int              W     = 16,
   parameter int              LEN_W = 4,
   parameter logic [W-1:0]    RST   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [W-1:0]     ld_data,
   input  logic             step_en,
   input  logic [LEN_W-1:0] step_len,
   output logic [W-1:0]     q
);

   logic [W-1:0] stepped;

   // Wraps modulo 2^W: the carry is simply not kept
   assign stepped = q + W'(step_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST;
      end else if (ld_en) begin
         q <= ld_data;
      end else if (step_en) begin
         q <= stepped;
      end
   end

endmodule

// File: rtl/seg_agu_comb.sv
module seg_agu_comb #(
   parameter int SEG_W  = 16,
   parameter int DISP_W = 16,
   parameter int SHIFT  = 4,
   parameter int PA_W   = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [DISP_W-1:0] disp,
   output logic [PA_W-1:0]   pa
);

   localparam int BASE_W = (SEG_W + SHIFT > DISP_W) ? (SEG_W + SHIFT) : DISP_W;
   localparam int SUM_W  = BASE_W + 1;

   logic [SUM_W-1:0] wide;

   assign wide = (SUM_W'(seg) << SHIFT) + SUM_W'(disp);

   // Narrowing to PA_W drops the carry, giving modulo 2^PA_W wrap
   assign pa = PA_W'(wide);

endmodule

// File: rtl/seg_agu.sv
module seg_agu
   import seg_agu_pkg::*;
#(
   parameter int               SEG_W  = 16,
   parameter int               DISP_W = 16,
   parameter int               SHIFT  = 4,
   parameter int               PA_W   = 20,
   parameter int               LEN_W  = 4,
   parameter logic [SEG_W-1:0]  RST_CS = '1,
   parameter logic [DISP_W-1:0] RST_IP = '0,
   parameter logic [DISP_W-1:0] RST_SP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_wr_en,
   input  logic [1:0]        seg_wr_sel,
   input  logic [SEG_W-1:0]  seg_wr_data,
   input  logic              ip_wr_en,
   input  logic [DISP_W-1:0] ip_wr_data,
   input  logic              adv_en,
   input  logic [LEN_W-1:0]  adv_len,
   input  logic              sp_wr_en,
   input  logic [DISP_W-1:0] sp_wr_data,
   input  logic [1:0]        acc_sel,
   input  logic [DISP_W-1:0] acc_disp,
   output logic [PA_W-1:0]   phys_addr,
   output logic [PA_W-1:0]   fetch_addr,
   output logic [PA_W-1:0]   stk_addr
);

   // Elaboration-time parameter checks
   if (LEN_W < 1 || LEN_W > DISP_W) begin : g_bad_len
      $error("seg_agu: LEN_W must lie in 1..DISP_W");
   end
   if (PA_W < 1 || SHIFT < 0 || SEG_W < 1 || DISP_W < 1) begin : g_bad_width
      $error("seg_agu: widths must be positive and SHIFT non-negative");
   end

   logic [SEG_COUNT-1:0][SEG_W-1:0] seg_q;
   logic [SEG_W-1:0]                acc_seg;
   logic [SEG_W-1:0]                cs_q;
   logic [SEG_W-1:0]                ss_q;
   logic [DISP_W-1:0]               ip_q;
   logic [DISP_W-1:0]               sp_q;

   seg_agu_segbank #(
      .SEG_W  (SEG_W),
      .RST_CS (RST_CS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .seg_q   (seg_q)
   );

   assign acc_seg = seg_q[acc_sel];
   assign cs_q    = seg_q[int'(SEG_CS)];
   assign ss_q    = seg_q[int'(SEG_SS)];

   seg_agu_ptr #(
      .W     (DISP_W),
      .LEN_W (LEN_W),
      .RST   (RST_IP)
   ) u_ip (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ip_wr_en),
      .ld_data  (ip_wr_data),
      .step_en  (adv_en),
      .step_len (adv_len),
      .q        (ip_q)
   );

   seg_agu_ptr #(
      .W     (DISP_W),
      .LEN_W (LEN_W),
      .RST   (RST_SP)
   ) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (sp_wr_en),
      .ld_data  (sp_wr_data),
      .step_en  (1'b0),
      .step_len ('0),
      .q        (sp_q)
   );

   seg_agu_comb #(
      .SEG_W (SEG_W), .DISP_W (DISP_W), .SHIFT (SHIFT), .PA_W (PA_W)
   ) u_acc (
      .seg  (acc_seg),
      .disp (acc_disp),
      .pa   (phys_addr)
   );

   seg_agu_comb #(
      .SEG_W (SEG_W), .DISP_W (DISP_W), .SHIFT (SHIFT), .PA_W (PA_W)
   ) u_fetch (
      .seg  (cs_q),
      .disp (ip_q),
      .pa   (fetch_addr)
   );

   seg_agu_comb #(
      .SEG_W (SEG_W), .DISP_W (DISP_W), .SHIFT (SHIFT), .PA_W (PA_W)
   ) u_stk (
      .seg  (ss_q),
      .disp (sp_q),
      .pa   (stk_addr)
   );

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
   parameter int SEG_W  = 16,
   parameter int DISP_W = 16,
   parameter int LEN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seg_wr_en,
   input logic [1:0]        seg_wr_sel,
   input logic              ip_wr_en,
   input logic [DISP_W-1:0] ip_wr_data,
   input logic              adv_en,
   input logic [LEN_W-1:0]  adv_len,
   input logic              sp_wr_en,
   input logic [DISP_W-1:0] sp_wr_data,
   input logic [SEG_W-1:0]  cs_q,
   input logic [DISP_W-1:0] ip_q,
   input logic [DISP_W-1:0] sp_q
);

   AST_IP_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ip_wr_en |=> ip_q == $past(ip_wr_data)); // R8

   AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !ip_wr_en) |=> ip_q == DISP_W'($past(ip_q) + DISP_W'($past(adv_len)))); // R5

   AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_en && !ip_wr_en) |=> $stable(ip_q)); // R10

   AST_CS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_wr_en && seg_wr_sel == 2'b01) |=> $stable(cs_q)); // R5

   AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_en |=> sp_q == $past(sp_wr_data)); // R9

   AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sp_wr_en |=> $stable(sp_q)); // R9

endmodule

bind seg_agu seg_agu_chk #(
   .SEG_W  (SEG_W),
   .DISP_W (DISP_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seg_wr_en  (seg_wr_en),
   .seg_wr_sel (seg_wr_sel),
   .ip_wr_en   (ip_wr_en),
   .ip_wr_data (ip_wr_data),
   .adv_en     (adv_en),
   .adv_len    (adv_len),
   .sp_wr_en   (sp_wr_en),
   .sp_wr_data (sp_wr_data),
   .cs_q       (cs_q),
   .ip_q       (ip_q),
   .sp_q       (sp_q)
);

// File: tb/seg_agu_test.sv
module seg_agu_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        seg_wr_en;
   logic [1:0]  seg_wr_sel;
   logic [15:0] seg_wr_data;
   logic        ip_wr_en;
   logic [15:0] ip_wr_data;
   logic        adv_en;
   logic [3:0]  adv_len;
   logic        sp_wr_en;
   logic [15:0] sp_wr_data;
   logic [1:0]  acc_sel;
   logic [15:0] acc_disp;
   logic [19:0] phys_addr;
   logic [19:0] fetch_addr;
   logic [19:0] stk_addr;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // Bench model of the architectural state
   logic [15:0] sh_seg [4];
   logic [15:0] sh_ip;
   logic [15:0] sh_sp;

   always #(CLK_PERIOD / 2) clk = ~clk;

   seg_agu uut (
      .clk (clk), .rst_n (rst_n),
      .seg_wr_en (seg_wr_en), .seg_wr_sel (seg_wr_sel), .seg_wr_data (seg_wr_data),
      .ip_wr_en (ip_wr_en), .ip_wr_data (ip_wr_data),
      .adv_en (adv_en), .adv_len (adv_len),
      .sp_wr_en (sp_wr_en), .sp_wr_data (sp_wr_data),
      .acc_sel (acc_sel), .acc_disp (acc_disp),
      .phys_addr (phys_addr), .fetch_addr (fetch_addr), .stk_addr (stk_addr)
   );

   function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] d);
      logic [20:0] t;
      t = {1'b0, s, 4'b0000} + {5'b00000, d};
      return t[19:0];
   endfunction

   task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic probe(input string req, input logic [1:0] sel, input logic [15:0] d);
      acc_sel  = sel;
      acc_disp = d;
      #1;
      chk(req, phys_addr, pa(sh_seg[sel], d));
   endtask

   task automatic wr_seg(input logic [1:0] sel, input logic [15:0] v);
      seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
      @(negedge clk);
      seg_wr_en = 1'b0;
      sh_seg[sel] = v;
   endtask

   task automatic wr_ip(input logic [15:0] v);
      ip_wr_en = 1'b1; ip_wr_data = v;
      @(negedge clk);
      ip_wr_en = 1'b0;
      sh_ip = v;
   endtask

   task automatic advance(input logic [3:0] l);
      adv_en = 1'b1; adv_len = l;
      @(negedge clk);
      adv_en = 1'b0;
      sh_ip = sh_ip + {12'h000, l};
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
      ip_wr_en = 0; ip_wr_data = 0; adv_en = 0; adv_len = 0;
      sp_wr_en = 0; sp_wr_data = 0; acc_sel = 0; acc_disp = 0;
      sh_seg[0] = 16'h0000; sh_seg[1] = 16'hFFFF; sh_seg[2] = 16'h0000; sh_seg[3] = 16'h0000;
      sh_ip = 16'h0000; sh_sp = 16'h0000;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 fetch in reset", fetch_addr, 20'hFFFF0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fetch after reset", fetch_addr, 20'hFFFF0);
      chk("R1 stack after reset", stk_addr, 20'h00000);
      probe("R1 extra segment zero", 2'b00, 16'h1234);
      probe("R1 data segment zero", 2'b11, 16'h0042);
   endtask

   task automatic t_select;
      wr_seg(2'b00, 16'h1000);
      wr_seg(2'b01, 16'h2000);
      wr_seg(2'b10, 16'h3000);
      wr_seg(2'b11, 16'h4000);
      probe("R2 sel 00 extra", 2'b00, 16'h0ABC);
      chk("R2 extra value", phys_addr, 20'h10ABC);
      probe("R2 sel 01 code", 2'b01, 16'h0ABC);
      chk("R2 code value", phys_addr, 20'h20ABC);
      probe("R2 sel 10 stack", 2'b10, 16'h0ABC);
      chk("R2 stack value", phys_addr, 20'h30ABC);
      probe("R2 sel 11 data", 2'b11, 16'h0ABC);
      chk("R2 data value", phys_addr, 20'h40ABC);
      // Only the named segment changes (R9)
      wr_seg(2'b11, 16'h5555);
      for (int s = 0; s < 4; s++) probe("R9 only selected segment written", 2'(s), 16'h0001);
   endtask

   task automatic t_wrap;
      wr_seg(2'b11, 16'hFFFF);
      probe("R3 FFFF:0010 wraps", 2'b11, 16'h0010);
      chk("R3 wrap to zero", phys_addr, 20'h00000);
      probe("R3 FFFF:FFFF wraps", 2'b11, 16'hFFFF);
      chk("R3 wrap value", phys_addr, 20'h0FFEF);
      wr_seg(2'b00, 16'hF000);
      probe("R3 top of space", 2'b00, 16'hFFFF);
      chk("R3 top value", phys_addr, 20'hFFFFF);
   endtask

   task automatic t_fetch;
      wr_seg(2'b01, 16'h1234);
      wr_ip(16'h0100);
      chk("R4 fetch after ip load", fetch_addr, 20'h12440);
      advance(4'd3);
      chk("R5 advance by 3", fetch_addr, 20'h12443);
      advance(4'd15);
      chk("R5 advance by 15", fetch_addr, pa(16'h1234, sh_ip));
      wr_ip(16'hFFFE);
      advance(4'd5);
      chk("R5 ip wraps, code seg kept", fetch_addr, 20'h12343);
   endtask

   task automatic t_priority;
      ip_wr_en = 1'b1; ip_wr_data = 16'hFFFF; adv_en = 1'b1; adv_len = 4'd7;
      @(negedge clk);
      ip_wr_en = 1'b0; adv_en = 1'b0;
      sh_ip = 16'hFFFF;
      chk("R8 load beats advance", fetch_addr, pa(sh_seg[1], 16'hFFFF));
   endtask

   task automatic t_hold;
      repeat (3) @(negedge clk);
      chk("R10 fetch holds when idle", fetch_addr, pa(sh_seg[1], sh_ip));
      chk("R9 stack pointer holds", stk_addr, pa(sh_seg[2], sh_sp));
   endtask

   task automatic t_stack;
      wr_seg(2'b10, 16'h2000);
      sp_wr_en = 1'b1; sp_wr_data = 16'hFFFE;
      @(negedge clk);
      sp_wr_en = 1'b0;
      sh_sp = 16'hFFFE;
      chk("R6 stack address", stk_addr, 20'h2FFFE);
      chk("R9 sp load", stk_addr, pa(16'h2000, 16'hFFFE));
   endtask

   task automatic t_latency;
      acc_sel = 2'b00; acc_disp = 16'h0002;
      seg_wr_en = 1'b1; seg_wr_sel = 2'b00; seg_wr_data = 16'hABCD;
      #1;
      chk("R7 old value before edge", phys_addr, pa(sh_seg[0], 16'h0002));
      @(negedge clk);
      seg_wr_en = 1'b0;
      sh_seg[0] = 16'hABCD;
      #1;
      chk("R7 new value after edge", phys_addr, 20'hABCD2);
      ip_wr_en = 1'b1; ip_wr_data = 16'h0040;
      #1;
      chk("R7 ip load not yet visible", fetch_addr, pa(sh_seg[1], sh_ip));
      @(negedge clk);
      ip_wr_en = 1'b0;
      sh_ip = 16'h0040;
      chk("R7 ip load visible", fetch_addr, pa(sh_seg[1], 16'h0040));
   endtask

   initial begin
      t_reset();
      t_select();
      t_wrap();
      t_fetch();
      t_priority();
      t_hold();
      t_stack();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule